// File: doc/BRIEF.md
# Matrix Operation Sequencer

This controller drives a ring of N arithmetic/memory cells that holds one square matrix operand in circulant form. On an accepted start request it decodes a 5-bit operation code and walks a two-level loop (outer index k, inner index l, both running 1..N). Each step produces a shared base address for the ring, row and column addresses for the streamed operand G, read-mode and write-mode bits, a write strobe, per-cell selects and an ALU opcode.

Every operation and transpose variant comes down to a different modulo-N index formula. After the arithmetic drain period the controller pulses done for one cycle. At the end of each arithmetic operation it flips the bank-select output, so that the next operation reads its operand from the bank that holds the previous result and no data is moved between operations.

Top module: `matseq_ctrl`

## Requirements
- R1: After reset, and whenever no operation is running, `base_o`, `grow_o`, `gcol_o`, `csel_o`, `we_o`, `rd_mode_o`, `wr_mode_o`, `alu_op_o`, `done_o` and `bank_o` are all zero. This holds until an operation starts.
- R2: `op_i[3:0]` selects the operation: 1 load, 2 unload, 3 direct product, 4 transposed product, 5 matrix-vector, 6 transposed matrix-vector, 7 vector-matrix, 8 vector-transposed-matrix, 9 add, 10 subtract, 11 element-wise product, 12 scalar, 13 scalar-transposed. Values 0, 14 and 15 are ignored: no step is issued and done stays low.
- R3: The direct product (code 3) steps through k then l over N² steps with base = (N−k−l+1) mod N, G row = (k+l−1) mod N and G column = k−1. Read mode and write mode are both 1, the ALU opcode is 2 (multiply-accumulate), and every cell is selected.
- R4: The transposed product (code 4) uses base = ((k mod N)+l−1) mod N with the same G addressing as R3. Read mode is 0, write mode is 1 and the ALU opcode is 2.
- R5: Add, subtract and element-wise product (codes 9, 10, 11) use base = k−1, G row = k−1, G column = l−1 and a one-hot cell select with bit l−1 set. Read and write mode are 0. The ALU opcode is 3, 4 and 5 respectively.
- R6: The scalar operations (codes 12, 13) issue N steps, with base equal to the step number minus one and G row and G column both 0. All cells are selected and the ALU opcode is 6. Read mode is 0 for code 12 and 1 for code 13, and write mode is 0.
- R7: The vector operations fix k = 1 and issue N steps. Codes 5 and 6 use the R3 and R4 formulas with write mode 1 and read mode 1 and 0 respectively. Codes 7 and 8 use the R4 and R3 formulas with G row and G column swapped, write mode 0 and read mode 0 and 1 respectively.
- R8: `op_i[4]` = 1 selects the transpose of G by swapping the G row and G column outputs of any operation.
- R9: After the start is accepted on a clock edge, `done_o` is high for exactly one cycle, T edges later. T is N²+7 for codes 3, 4 and 9–11, N+7 for codes 5–8 and 12–13, N²+8 for load and N²+6 for unload.
- R10: A start request that arrives while an operation is running is ignored. The running operation keeps its opcode and timing, and no further operation follows it.
- R11: `bank_o` toggles exactly once, in the cycle that done rises, at the end of each arithmetic operation (codes 3–13). It does not change on load, on unload, or at any other time.
- R12: `we_o` is high on every issued step of every operation except unload, and is low during the drain cycles after the last step.
- R13: Load (code 1) and unload (code 2) use the R5 addressing with ALU opcode 1 and 0 respectively. Write mode is 1 for load and 0 for unload, and read mode is 0 for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| op_i | input | 5 | Operation code; bit 4 transposes G |
| base_o | output | $clog2(N) | Shared base address for the ring |
| grow_o | output | $clog2(N) | Row address of the G element |
| gcol_o | output | $clog2(N) | Column address of the G element |
| rd_mode_o | output | 1 | Read addressing mode |
| wr_mode_o | output | 1 | Write addressing mode |
| we_o | output | 1 | Write strobe for the issued step |
| csel_o | output | N | Per-cell select |
| alu_op_o | output | 3 | ALU opcode |
| bank_o | output | 1 | Bank holding the current operand |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the controller with N = 3, which is not a power of two. The modulo-N wrap of the base and G-row formulas must therefore be produced by explicit subtraction rather than by dropping bits. With N = 3 every wrap case appears within nine steps. The matrix, vector and load/unload durations (16, 10, 17 and 15 cycles) are all distinct. Each duration can therefore be checked to the exact cycle in a short run.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam logic [3:0] OC_LOAD   = 4'd1;
  localparam logic [3:0] OC_UNLOAD = 4'd2;
  localparam logic [3:0] OC_MUL    = 4'd3;
  localparam logic [3:0] OC_MULT   = 4'd4;
  localparam logic [3:0] OC_MV     = 4'd5;
  localparam logic [3:0] OC_MVT    = 4'd6;
  localparam logic [3:0] OC_VM     = 4'd7;
  localparam logic [3:0] OC_VMT    = 4'd8;
  localparam logic [3:0] OC_ADD    = 4'd9;
  localparam logic [3:0] OC_SUB    = 4'd10;
  localparam logic [3:0] OC_DOT    = 4'd11;
  localparam logic [3:0] OC_SCL    = 4'd12;
  localparam logic [3:0] OC_SCLT   = 4'd13;

  typedef enum logic [2:0] {
    ALU_NOP   = 3'd0,
    ALU_PASS  = 3'd1,
    ALU_MAC   = 3'd2,
    ALU_ADD   = 3'd3,
    ALU_SUB   = 3'd4,
    ALU_MUL   = 3'd5,
    ALU_SCALE = 3'd6
  } alu_e;

  typedef enum logic [1:0] {
    CLS_MM   = 2'd0,
    CLS_VEC  = 2'd1,
    CLS_LOAD = 2'd2,
    CLS_UNLD = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    F_DIR  = 2'd0,
    F_TRN  = 2'd1,
    F_ELEM = 2'd2,
    F_SCAL = 2'd3
  } form_e;

  typedef struct packed {
    logic  valid;
    cls_e  cls;
    form_e form;
    alu_e  alu;
    logic  rd;
    logic  wr;
    logic  swap;
    logic  arith;
  } dec_t;
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  logic [4:0] op_i,
  output dec_t       dec_o
);
  logic vm;

  always_comb begin
    dec_o       = '0;
    dec_o.valid = 1'b1;
    dec_o.cls   = CLS_MM;
    dec_o.form  = F_ELEM;
    dec_o.alu   = ALU_NOP;
    vm          = 1'b0;
    case (op_i[3:0])
      OC_LOAD:   begin dec_o.cls = CLS_LOAD; dec_o.alu = ALU_PASS; dec_o.wr = 1'b1; end
      OC_UNLOAD: begin dec_o.cls = CLS_UNLD; end
      OC_MUL:    begin dec_o.form = F_DIR; dec_o.alu = ALU_MAC; dec_o.rd = 1'b1; dec_o.wr = 1'b1; end
      OC_MULT:   begin dec_o.form = F_TRN; dec_o.alu = ALU_MAC; dec_o.wr = 1'b1; end
      OC_MV:     begin dec_o.cls = CLS_VEC; dec_o.form = F_DIR; dec_o.alu = ALU_MAC;
                       dec_o.rd = 1'b1; dec_o.wr = 1'b1; end
      OC_MVT:    begin dec_o.cls = CLS_VEC; dec_o.form = F_TRN; dec_o.alu = ALU_MAC; dec_o.wr = 1'b1; end
      OC_VM:     begin dec_o.cls = CLS_VEC; dec_o.form = F_TRN; dec_o.alu = ALU_MAC; vm = 1'b1; end
      OC_VMT:    begin dec_o.cls = CLS_VEC; dec_o.form = F_DIR; dec_o.alu = ALU_MAC;
                       dec_o.rd = 1'b1; vm = 1'b1; end
      OC_ADD:    dec_o.alu = ALU_ADD;
      OC_SUB:    dec_o.alu = ALU_SUB;
      OC_DOT:    dec_o.alu = ALU_MUL;
      OC_SCL:    begin dec_o.cls = CLS_VEC; dec_o.form = F_SCAL; dec_o.alu = ALU_SCALE; end
      OC_SCLT:   begin dec_o.cls = CLS_VEC; dec_o.form = F_SCAL; dec_o.alu = ALU_SCALE; dec_o.rd = 1'b1; end
      default:   dec_o.valid = 1'b0;
    endcase
    dec_o.swap  = vm ^ op_i[4];
    dec_o.arith = dec_o.valid && (dec_o.cls == CLS_MM || dec_o.cls == CLS_VEC);
  end
endmodule

// File: rtl/mseq_loop.sv
module mseq_loop #(
  parameter int N  = 4,
  parameter int AW = $clog2(N),
  parameter int CW = $clog2(N*N+9)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          single_i,
  input  logic [CW-1:0] total_i,
  output logic          busy_o,
  output logic          act_o,
  output logic          done_o,
  output logic [AW-1:0] kk_o,
  output logic [AW-1:0] ll_o
);
  localparam logic [CW-1:0] LIM_MAT = CW'(N*N);
  localparam logic [CW-1:0] LIM_VEC = CW'(N);
  localparam logic [AW-1:0] LAST    = AW'(N-1);

  logic [CW-1:0] cnt_q, tot_q;
  logic          single_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      cnt_q    <= '0;
      tot_q    <= '0;
      single_q <= 1'b0;
      kk_o     <= '0;
      ll_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        busy_o   <= 1'b1;
        cnt_q    <= '0;
        tot_q    <= total_i;
        single_q <= single_i;
        kk_o     <= '0;
        ll_o     <= '0;
      end else if (busy_o) begin
        if (cnt_q == tot_q - 1'b1) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
        cnt_q <= cnt_q + 1'b1;
        if (ll_o == LAST) begin
          ll_o <= '0;
          kk_o <= (kk_o == LAST) ? '0 : kk_o + 1'b1;
        end else begin
          ll_o <= ll_o + 1'b1;
        end
      end
    end
  end

  assign act_o = busy_o && (cnt_q < (single_q ? LIM_VEC : LIM_MAT));
endmodule

// File: rtl/mseq_addr.sv
module mseq_addr
  import mseq_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = $clog2(N)
) (
  input  logic          act_i,
  input  form_e         form_i,
  input  logic          swap_i,
  input  logic [AW-1:0] kk_i,
  input  logic [AW-1:0] ll_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] grow_o,
  output logic [AW-1:0] gcol_o,
  output logic [N-1:0]  csel_o
);
  localparam int SW = AW + 1;
  localparam logic [SW-1:0] NS   = SW'(N);
  localparam logic [AW-1:0] LAST = AW'(N-1);

  logic [SW-1:0] s_sum, s_mod, t_sum, t_mod, neg;
  logic [AW-1:0] kk1, gr, gc;

  // (k+l-1) mod N and its negation, with k=kk+1, l=ll+1
  assign s_sum = SW'(kk_i) + SW'(ll_i) + 1'b1;
  assign s_mod = (s_sum >= NS) ? s_sum - NS : s_sum;
  assign neg   = (s_mod == '0) ? '0 : NS - s_mod;
  assign kk1   = (kk_i == LAST) ? '0 : kk_i + 1'b1;
  assign t_sum = SW'(kk1) + SW'(ll_i);
  assign t_mod = (t_sum >= NS) ? t_sum - NS : t_sum;

  always_comb begin
    base_o = '0;
    gr     = '0;
    gc     = '0;
    csel_o = '0;
    if (act_i) begin
      csel_o = '1;
      case (form_i)
        F_DIR:  begin base_o = AW'(neg);   gr = AW'(s_mod); gc = kk_i; end
        F_TRN:  begin base_o = AW'(t_mod); gr = AW'(s_mod); gc = kk_i; end
        F_ELEM: begin base_o = kk_i; gr = kk_i; gc = ll_i; csel_o = N'(1) << ll_i; end
        default: base_o = ll_i;
      endcase
    end
  end

  assign grow_o = swap_i ? gc : gr;
  assign gcol_o = swap_i ? gr : gc;
endmodule

// File: rtl/matseq_ctrl.sv
module matseq_ctrl
  import mseq_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [4:0]    op_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] grow_o,
  output logic [AW-1:0] gcol_o,
  output logic          rd_mode_o,
  output logic          wr_mode_o,
  output logic          we_o,
  output logic [N-1:0]  csel_o,
  output logic [2:0]    alu_op_o,
  output logic          bank_o,
  output logic          done_o
);
  localparam int CW = $clog2(N*N+9);
  localparam logic [CW-1:0] T_MM   = CW'(N*N+7);
  localparam logic [CW-1:0] T_VEC  = CW'(N+7);
  localparam logic [CW-1:0] T_LOAD = CW'(N*N+8);
  localparam logic [CW-1:0] T_UNLD = CW'(N*N+6);

  dec_t          dec_in, dec_q;
  logic [4:0]    op_q;
  logic          busy, act, go, loop_done;
  logic [AW-1:0] kk, ll;
  logic [CW-1:0] total;

  mseq_decode u_dec_in  (.op_i(op_i), .dec_o(dec_in));
  mseq_decode u_dec_run (.op_i(op_q), .dec_o(dec_q));

  assign go = start_i && !busy && dec_in.valid;

  always_comb begin
    case (dec_in.cls)
      CLS_MM:   total = T_MM;
      CLS_VEC:  total = T_VEC;
      CLS_LOAD: total = T_LOAD;
      default:  total = T_UNLD;
    endcase
  end

  mseq_loop #(.N(N), .AW(AW), .CW(CW)) u_loop (
    .clk_i, .rst_ni,
    .go_i    (go),
    .single_i(dec_in.cls == CLS_VEC),
    .total_i (total),
    .busy_o  (busy),
    .act_o   (act),
    .done_o  (loop_done),
    .kk_o    (kk),
    .ll_o    (ll)
  );

  mseq_addr #(.N(N), .AW(AW)) u_addr (
    .act_i (act),
    .form_i(dec_q.form),
    .swap_i(dec_q.swap),
    .kk_i  (kk),
    .ll_i  (ll),
    .base_o, .grow_o, .gcol_o, .csel_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      bank_o <= 1'b0;
    end else begin
      if (go) op_q <= op_i;
      if (busy && dec_q.arith && !go && u_loop.cnt_q == u_loop.tot_q - 1'b1) bank_o <= ~bank_o;
    end
  end

  assign done_o    = loop_done;
  assign we_o      = act && dec_q.cls != CLS_UNLD;
  assign rd_mode_o = busy && dec_q.rd;
  assign wr_mode_o = busy && dec_q.wr;
  assign alu_op_o  = busy ? dec_q.alu : ALU_NOP;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int N  = 4,
  parameter int AW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [4:0]    op_i,
  input logic [AW-1:0] base_o,
  input logic [AW-1:0] grow_o,
  input logic [AW-1:0] gcol_o,
  input logic          we_o,
  input logic [N-1:0]  csel_o,
  input logic [2:0]    alu_op_o,
  input logic          bank_o,
  input logic          done_o,
  input logic          busy_i
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!we_o && csel_o == '0 && alu_op_o == 3'd0));

  p_bad_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i && (op_i[3:0] == 4'd0 || op_i[3:0] > 4'd13)) |=> !busy_i);

  p_addr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (int'(base_o) < N && int'(grow_o) < N && int'(gcol_o) < N));

  p_elem_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && (alu_op_o == 3'd3 || alu_op_o == 3'd4 || alu_op_o == 3'd5)) |-> $countones(csel_o) == 1);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_i && $past(busy_i)));

  p_bank_on_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank_o) |-> done_o);

  p_we_in_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> busy_i);
endmodule

bind matseq_ctrl mseq_chk #(.N(N), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .start_i, .op_i, .base_o, .grow_o, .gcol_o, .we_o,
  .csel_o, .alu_op_o, .bank_o, .done_o, .busy_i(busy)
);

// File: tb/sim_matseq_ctrl.sv
`timescale 1ns/1ps
module sim_matseq_ctrl;
  localparam int N  = 3;
  localparam int AW = $clog2(N);

  logic          clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [4:0]    op_i = '0;
  logic [AW-1:0] base_o, grow_o, gcol_o;
  logic          rd_mode_o, wr_mode_o, we_o, bank_o, done_o;
  logic [N-1:0]  csel_o;
  logic [2:0]    alu_op_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  matseq_ctrl #(.N(N)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_vec(input int c);
    return (c >= 5 && c <= 8) || c == 12 || c == 13;
  endfunction

  function automatic int dur(input int c);
    if (c == 1) return N*N+8;
    if (c == 2) return N*N+6;
    if (is_vec(c)) return N+7;
    return N*N+7;
  endfunction

  // expected step outputs, 1-based k,l
  task automatic exp_step(input logic [4:0] op, input int j,
                          output int b, output int gr, output int gc, output int cs);
    int c, k, l, t;
    c = op[3:0];
    if (is_vec(c)) begin k = 1; l = j + 1; end
    else begin k = j / N + 1; l = j % N + 1; end
    cs = (1 << N) - 1;
    case (c)
      1, 2, 9, 10, 11: begin b = k-1; gr = k-1; gc = l-1; cs = 1 << (l-1); end
      3, 5, 8: begin b = ((N-k-l+1) % N + N) % N; gr = (k+l-1) % N; gc = k-1; end
      default: begin b = ((k % N) + l - 1) % N; gr = (k+l-1) % N; gc = k-1; end
    endcase
    if (c == 12 || c == 13) begin b = l-1; gr = 0; gc = 0; end
    if (c == 7 || c == 8) begin t = gr; gr = gc; gc = t; end
    if (op[4]) begin t = gr; gr = gc; gc = t; end
  endtask

  task automatic exp_mode(input int c, output int rd, output int wr, output int alu);
    case (c)
      1: begin rd=0; wr=1; alu=1; end
      2: begin rd=0; wr=0; alu=0; end
      3, 5: begin rd=1; wr=1; alu=2; end
      4, 6: begin rd=0; wr=1; alu=2; end
      7: begin rd=0; wr=0; alu=2; end
      8: begin rd=1; wr=0; alu=2; end
      9: begin rd=0; wr=0; alu=3; end
      10: begin rd=0; wr=0; alu=4; end
      11: begin rd=0; wr=0; alu=5; end
      12: begin rd=0; wr=0; alu=6; end
      default: begin rd=1; wr=0; alu=6; end
    endcase
  endtask

  // run one operation and check every step, done timing and bank
  task automatic run_op(input logic [4:0] op, input string req, input bit mid_start);
    int c, T, it, b, gr, gc, cs, rd, wr, alu;
    logic bank0;
    c = op[3:0];
    T = dur(c);
    it = is_vec(c) ? N : N*N;
    exp_mode(c, rd, wr, alu);
    bank0 = bank_o;
    @(negedge clk_i); start_i = 1'b1; op_i = op;
    @(posedge clk_i);
    for (int j = 0; j < T; j++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (mid_start && j == 2) begin start_i = 1'b1; op_i = 5'd9; end
      if (j < it) begin
        exp_step(op, j, b, gr, gc, cs);
        chk(base_o == AW'(b) && grow_o == AW'(gr) && gcol_o == AW'(gc), {req, " addr"},
            {base_o, grow_o, gcol_o}, {b[AW-1:0], gr[AW-1:0], gc[AW-1:0]});
        chk(csel_o == N'(cs), {req, " csel"}, csel_o, cs);
        chk(we_o == (c != 2), {req, " R12 we"}, we_o, c != 2);
      end else if (j == it) begin
        chk(!we_o && csel_o == '0, {req, " R12 drain"}, we_o, 0);
      end
      if (j == 0 || j == T-1)
        chk(rd_mode_o == rd[0] && wr_mode_o == wr[0] && alu_op_o == alu[2:0], {req, " mode"},
            {rd_mode_o, wr_mode_o, alu_op_o}, {rd[0], wr[0], alu[2:0]});
      if (j == T-1) chk(!done_o, {req, " R9 early"}, done_o, 0);
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk(done_o, {req, " R9 done"}, done_o, 1);
    chk(bank_o == (bank0 ^ (c >= 3)), {req, " R11 bank"}, bank_o, bank0 ^ (c >= 3));
    @(negedge clk_i);
    chk(!done_o, {req, " R9 pulse"}, done_o, 0);
  endtask

  task automatic t_reset();
    chk(base_o == 0 && grow_o == 0 && gcol_o == 0 && csel_o == 0, "R1 addr", base_o, 0);
    chk(!we_o && !rd_mode_o && !wr_mode_o && alu_op_o == 0, "R1 ctrl", alu_op_o, 0);
    chk(!done_o && !bank_o, "R1 done/bank", {done_o, bank_o}, 0);
  endtask

  task automatic t_unused(input logic [4:0] op);
    logic bank0;
    int seen;
    bank0 = bank_o;
    seen = 0;
    @(negedge clk_i); start_i = 1'b1; op_i = op;
    @(negedge clk_i); start_i = 1'b0;
    for (int j = 0; j < N*N+10; j++) begin
      @(negedge clk_i);
      if (done_o || we_o || alu_op_o != 0) seen++;
    end
    chk(seen == 0, "R2 unused code", seen, 0);
    chk(bank_o == bank0, "R2 bank", bank_o, bank0);
  endtask

  task automatic t_restart();
    int seen;
    run_op(5'd3, "R10 busy start", 1'b1);
    seen = 0;
    for (int j = 0; j < N*N+10; j++) begin
      @(negedge clk_i);
      if (done_o || we_o) seen++;
    end
    chk(seen == 0, "R10 no second run", seen, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_op(5'd1,  "R13 load", 0);
    run_op(5'd3,  "R3 direct", 0);
    run_op(5'd4,  "R4 transposed", 0);
    run_op(5'd9,  "R5 add", 0);
    run_op(5'd10, "R5 sub", 0);
    run_op(5'd11, "R5 dot", 0);
    run_op(5'd12, "R6 scalar", 0);
    run_op(5'd13, "R6 scalar-t", 0);
    run_op(5'd5,  "R7 mv", 0);
    run_op(5'd6,  "R7 mv-t", 0);
    run_op(5'd7,  "R7 vm", 0);
    run_op(5'd8,  "R7 vm-t", 0);
    run_op(5'd19, "R8 g-transpose mul", 0);
    run_op(5'd23, "R8 g-transpose vm", 0);
    run_op(5'd25, "R8 g-transpose add", 0);
    run_op(5'd2,  "R11 unload", 0);
    t_unused(5'd0);
    t_unused(5'd14);
    t_unused(5'd31);
    t_restart();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule